// File: doc/BRIEF.md
# Match-controlled timer counter

The block is a 16-bit up-counter advanced by a programmable clock divider, with four compare channels watching it. Each channel holds a compare value and three enable bits. These bits choose whether a compare hit latches an interrupt flag, sends the counter back to zero, or halts counting and drops the run bit. Software programs the block through a plain synchronous port: it writes with address, data and write strobe, and reads combinationally at the presented address.

A compare hit is taken on the divider wrap that ends the counter's stay at the compare value. Each counter value therefore produces at most one hit per pass. A channel set to reset gives a period of compare value plus one counter steps. A channel set to stop leaves the counter frozen on the compare value. Latched flags stay set until software clears them with a write of ones. The interrupt line is high while any flag is set.

Register map (address: content): 0x0 control (bit 0 run, bit 1 hold-at-zero); 0x1 divider limit; 0x2 channel control word; 0x3 interrupt flags (read, write 1 to clear); 0x4 counter (read only); 0x8+n compare value of channel n.

Top module: `match_timer`

## Requirements
- R1: While run (control bit 0) is 1 and hold is 0, the divider counts clocks from 0 up to the divider limit L. The counter steps by one on the clock after the divider reaches L, so it advances once every L+1 clocks.
- R2: While run is 0, the counter and the divider keep their values.
- R3: A hit on channel n occurs on the step clock when the counter equals its compare value. If bit 3n of the channel control word is 1, flag n is set. If that bit is 0, the hit leaves the flag alone.
- R4: If bit 3n+1 is 1, a hit on channel n loads the counter with zero instead of incrementing it, so the counter repeats 0 to the compare value.
- R5: If bit 3n+2 is 1, a hit on channel n keeps the counter at its value, restarts the divider and clears the run bit, which reads 0 at address 0x0.
- R6: Hits on several channels in one step set all their enabled flags, and a stop on any hitting channel wins over a reset on another.
- R7: Writing address 0x3 clears each flag whose data bit is 1 and leaves the rest. A set in the same clock wins over the clear.
- R8: irq_o is 1 exactly when at least one flag is set.
- R9: While hold (control bit 1) is 1, the counter and the divider are held at zero.
- R10: After reset every register is zero: no run, no hold, all channel control bits off, flags clear, counter zero.
- R11: match_o[n] is 1 while the counter equals the compare value of channel n.
- R12: rdata_o returns, at the address given, the register contents listed in the map, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Read data at addr_i |
| irq_o | output | 1 | Interrupt level |
| match_o | output | 4 | Per-channel compare equality |

## Verification
The hardest case is two channels hitting on the same step, one set to reset and one set to stop. To reach it, the counter is held at zero through the hold bit while both compare values are set equal and the control word is loaded, and then it is released. This makes the coincident hit land on a known step. A reference model in the bench replays every register write. A seeded random phase with small compare values and divider limits then brings about many more coincident hits, flag clears landing on set clocks, and stops racing against run-bit writes.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CFG_W  = 3;
  localparam int unsigned CFG_INT  = 0;
  localparam int unsigned CFG_RST  = 1;
  localparam int unsigned CFG_STOP = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_LIMIT = 4'h1;
  localparam logic [ADDR_W-1:0] A_MCTL  = 4'h2;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'h3;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'h4;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'h8;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         hold_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  assign tick_o = run_i && !hold_i && (pc_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (hold_i)           pc_q <= '0;
    else if (run_i) pc_q <= (pc_q >= limit_i) ? '0 : pc_q + 1'b1;
  end

  // R9
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> pc_q == '0);
  // R2
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hold_i) |=> pc_q == $past(pc_q));
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] tc_i,
  input  logic         tick_i,
  input  logic [2:0]   cfg_i,
  output logic [W-1:0] cmp_o,
  output logic         eq_o,
  output logic         set_o,
  output logic         rst_o,
  output logic         stop_o
);
  import match_timer_pkg::*;
  logic [W-1:0] cmp_q;
  logic         hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (wr_i) cmp_q <= wdata_i;
  end

  assign cmp_o  = cmp_q;
  assign eq_o   = (tc_i == cmp_q);
  assign hit    = tick_i && eq_o;
  assign set_o  = hit && cfg_i[CFG_INT];
  assign rst_o  = hit && cfg_i[CFG_RST];
  assign stop_o = hit && cfg_i[CFG_STOP];

  // R12
  cmp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cmp_q == $past(wdata_i));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [match_timer_pkg::ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  input  logic                                we_i,
  output logic [DATA_W-1:0]                   rdata_o,
  output logic                                irq_o,
  output logic [N_CH-1:0]                     match_o
);
  import match_timer_pkg::*;
  localparam int unsigned MCTL_W = CFG_W * N_CH;
  localparam int unsigned IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic              run_q, hold_q, tick;
  logic [CNT_W-1:0]  limit_q, tc_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [N_CH-1:0]   flag_q, set_v, rst_v, stop_v, wr_cmp, clr_v;
  logic [CNT_W-1:0]  cmp_arr [N_CH];
  logic              any_stop, any_rst;
  logic              wr_ctrl, wr_limit, wr_mctl, wr_flag;

  assign wr_ctrl  = we_i && addr_i == A_CTRL;
  assign wr_limit = we_i && addr_i == A_LIMIT;
  assign wr_mctl  = we_i && addr_i == A_MCTL;
  assign wr_flag  = we_i && addr_i == A_FLAG;

  mt_prescaler #(.W(CNT_W)) u_psc (
    .clk_i, .rst_ni, .run_i(run_q), .hold_i(hold_q),
    .limit_i(limit_q), .tick_o(tick)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    assign wr_cmp[n] = we_i && addr_i == A_CMP0 + ADDR_W'(n);
    mt_channel #(.W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .wr_i(wr_cmp[n]), .wdata_i(wdata_i[CNT_W-1:0]),
      .tc_i(tc_q), .tick_i(tick), .cfg_i(mctl_q[CFG_W*n +: CFG_W]),
      .cmp_o(cmp_arr[n]), .eq_o(match_o[n]), .set_o(set_v[n]),
      .rst_o(rst_v[n]), .stop_o(stop_v[n])
    );

    // R7
    flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[n] && !(wr_flag && wdata_i[n])) |=> flag_q[n]);
    // R3
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_v[n] |=> flag_q[n]);
  end

  assign any_stop = |stop_v;
  assign any_rst  = |rst_v;
  assign clr_v    = wr_flag ? wdata_i[N_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      limit_q <= '0;
      mctl_q  <= '0;
      flag_q  <= '0;
      tc_q    <= '0;
    end else begin
      if (any_stop)     run_q <= 1'b0;
      else if (wr_ctrl) run_q <= wdata_i[0];
      if (wr_ctrl)  hold_q  <= wdata_i[1];
      if (wr_limit) limit_q <= wdata_i[CNT_W-1:0];
      if (wr_mctl)  mctl_q  <= wdata_i[MCTL_W-1:0];
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (hold_q)                  tc_q <= '0;
      else if (tick && !any_stop)  tc_q <= any_rst ? '0 : tc_q + 1'b1;
    end
  end

  assign irq_o = |flag_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1]) rdata_o[CNT_W-1:0] = cmp_arr[addr_i[IDX_W-1:0]];
    else begin
      case (addr_i)
        A_CTRL:  rdata_o[1:0]        = {hold_q, run_q};
        A_LIMIT: rdata_o[CNT_W-1:0]  = limit_q;
        A_MCTL:  rdata_o[MCTL_W-1:0] = mctl_q;
        A_FLAG:  rdata_o[N_CH-1:0]   = flag_q;
        A_COUNT: rdata_o[CNT_W-1:0]  = tc_q;
        default: rdata_o = '0;
      endcase
    end
  end

  // R1
  step_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !hold_q) |=> tc_q == $past(tc_q));
  // R4
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_rst && !any_stop && !hold_q) |=> tc_q == '0);
  // R5
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stop |=> (!run_q && tc_q == $past(tc_q)));
  // R9
  hold_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> tc_q == '0);
endmodule

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = 4'h4;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        irq;
  logic [3:0]  match;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] seen_match = '0;

  always #2 clk = ~clk;

  match_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .irq_o(irq), .match_o(match)
  );

  // reference model
  logic        m_run, m_hold;
  logic [15:0] m_lim, m_pc, m_tc;
  logic [11:0] m_mctl;
  logic [3:0]  m_flag;
  logic [15:0] m_cmp [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_lim = 0; m_pc = 0; m_tc = 0;
      m_mctl = 0; m_flag = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      logic tk, st, rs;
      logic [3:0] sv;
      tk = m_run && !m_hold && (m_pc >= m_lim);
      st = 0; rs = 0; sv = 0;
      for (int i = 0; i < 4; i++) if (tk && m_tc == m_cmp[i]) begin
        sv[i] = m_mctl[3*i]; rs |= m_mctl[3*i+1]; st |= m_mctl[3*i+2];
      end
      if (m_hold) m_pc = 0;
      else if (m_run) m_pc = (m_pc >= m_lim) ? 16'd0 : m_pc + 16'd1;
      if (m_hold) m_tc = 0;
      else if (tk && !st) m_tc = rs ? 16'd0 : m_tc + 16'd1;
      m_flag = (m_flag & ~((we && addr == 4'h3) ? wdata[3:0] : 4'h0)) | sv;
      if (st) m_run = 0;
      else if (we && addr == 4'h0) m_run = wdata[0];
      if (we && addr == 4'h0) m_hold = wdata[1];
      if (we && addr == 4'h1) m_lim = wdata;
      if (we && addr == 4'h2) m_mctl = wdata[11:0];
      for (int i = 0; i < 4; i++) if (we && addr == 4'(8 + i)) m_cmp[i] = wdata;
    end
  end

  function automatic logic [15:0] m_rd(input logic [3:0] a);
    if (a[3]) return m_cmp[a[1:0]];
    case (a)
      4'h0: return {14'd0, m_hold, m_run};
      4'h1: return m_lim;
      4'h2: return {4'd0, m_mctl};
      4'h3: return {12'd0, m_flag};
      4'h4: return m_tc;
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [3:0] m_eq();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = (m_tc == m_cmp[i]);
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    chk("R12 readback", rdata, m_rd(addr));
    chk("R8 irq", irq, |m_flag);
    chk("R11 match", match, m_eq());
    seen_match |= match;
    we = w; addr = a; wdata = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h4, 16'h0);
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    we = 0; addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    logic [15:0] held, mx;
    int zeros;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    expect_rd(4'h4, 16'h0, "R10 count");
    expect_rd(4'h0, 16'h0, "R10 ctrl");
    expect_rd(4'h2, 16'h0, "R10 mctl");
    expect_rd(4'h3, 16'h0, "R10 flags");
    chk("R10 irq", irq, 1'b0);

    // R1 divider, R3 no flag with int bit off
    wr(4'h1, 16'd3);
    wr(4'h8, 16'd2);
    wr(4'h9, 16'hFFFF); wr(4'hA, 16'hFFFF); wr(4'hB, 16'hFFFF);
    seen_match = '0;
    wr(4'h0, 16'h1);
    idle(40);
    expect_rd(4'h4, 16'd10, "R1 count after 40 clocks at limit 3");
    expect_rd(4'h3, 16'h0, "R3 flag stays clear when int bit off");
    chk("R11 channel 0 equality seen", seen_match[0], 1'b1);

    // R2 stopped counter keeps value
    wr(4'h0, 16'h0);
    idle(2);
    expect_rd(4'h4, m_tc, "R2 count sample");
    held = rdata;
    idle(20);
    expect_rd(4'h4, held, "R2 count unchanged while run=0");

    // R4 reset on match, period cmp+1
    wr(4'h0, 16'h2);
    wr(4'h1, 16'd0);
    wr(4'h8, 16'd4);
    wr(4'h2, 16'h002);
    wr(4'h0, 16'h1);
    mx = 0; zeros = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); we = 0; addr = 4'h4; #1;
      if (rdata > mx) mx = rdata;
      if (rdata == 0) zeros++;
    end
    chk("R4 max count equals compare value", mx, 16'd4);
    chk("R4 wraps to zero", 32'(zeros), 32'd3);

    // R5 stop on match
    wr(4'h0, 16'h2);
    wr(4'h8, 16'hFFFF);
    wr(4'h9, 16'd6);
    wr(4'h2, 16'h028);
    wr(4'h1, 16'd1);
    wr(4'h3, 16'hF);
    wr(4'h0, 16'h1);
    idle(40);
    expect_rd(4'h4, 16'd6, "R5 count frozen at compare");
    expect_rd(4'h0, 16'h0, "R5 run bit cleared");
    expect_rd(4'h3, 16'h2, "R3 flag 1 set");
    chk("R8 irq with flag", irq, 1'b1);

    // R6 coincident reset and stop
    wr(4'h0, 16'h2);
    wr(4'h8, 16'd3); wr(4'hA, 16'd3); wr(4'h9, 16'hFFFF);
    wr(4'h2, 16'h143);
    wr(4'h1, 16'd0);
    wr(4'h3, 16'hF);
    wr(4'h0, 16'h1);
    idle(20);
    expect_rd(4'h4, 16'd3, "R6 stop wins over reset");
    expect_rd(4'h3, 16'h5, "R6 both flags set");
    expect_rd(4'h0, 16'h0, "R6 run cleared");

    // R7 write-one-to-clear, R8
    wr(4'h3, 16'h1);
    idle(1);
    expect_rd(4'h3, 16'h4, "R7 only written bit cleared");
    chk("R8 irq still high", irq, 1'b1);
    wr(4'h3, 16'h4);
    idle(1);
    expect_rd(4'h3, 16'h0, "R7 all clear");
    chk("R8 irq low", irq, 1'b0);

    // R9 hold at zero
    wr(4'h0, 16'h3);
    idle(10);
    expect_rd(4'h4, 16'h0, "R9 held at zero");

    // random phase
    wr(4'h0, 16'h1);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) begin
        int k;
        k = $urandom_range(5);
        case (k)
          0: wr(4'h0, ($urandom_range(5) == 0) ? 16'(($urandom_range(3))) : 16'h1);
          1: wr(4'h1, 16'($urandom_range(3)));
          2: wr(4'h2, 16'($urandom_range(16'h0FFF)));
          3: wr(4'h3, 16'($urandom_range(15)));
          default: wr(4'(8 + $urandom_range(3)), 16'($urandom_range(15)));
        endcase
      end else step(1'b0, 4'($urandom_range(4)), 16'h0);
    end
    idle(1);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule